// File: doc/BRIEF.md
# PCIe MSI Capture and Interrupt Aggregator

This block sits beside a PCIe root port and turns inbound message-signalled interrupt writes into a single level-sensitive interrupt line. The vector space is split into groups ("sets") of equal size. Each set has its own 64-bit capture address. An inbound write whose address matches a set's address marks one vector of that set as pending. The written data value selects which vector.

Software programs the capture addresses and enables through a 32-bit register bus. It then reads a per-set summary to find which set needs service, and reads that set's status word. It acknowledges vectors by writing ones to the status word. Vectors behave as latched edge events: a captured write stays pending until software acknowledges it. The interrupt output is derived only from registered state, so it follows any register or capture change in the first cycle after the clock edge that makes the change.

Top module: `pcie_msi_aggregator`

## Requirements
- R1: There are 8 sets of 32 vectors, 256 vectors in total. Global vector n maps to set n/32, local index n%32. The capture address of set s is formed from two registers. The high word is at byte offset 0xC80+4s and the low word is at 0xC00+16s. Both read back what was written.
- R2: A write with `msi_valid` high sets one status bit, and only in a set whose capture address equals `msi_addr` and whose data value is 0 to 31. The bit set is the one whose index equals the data value. The set's status word is at 0xC00+16s+4, and the bit is visible from the following cycle. Other sets are unaffected.
- R3: The status word is write-1-to-clear. A 1 in bit k clears local vector k, and 0 bits leave their status unchanged.
- R4: Each set has a vector-enable word at 0xC00+16s+8. The read-only summary register at 0x184 carries bit 8+s. That bit equals the OR of set s's status ANDed with its vector-enable word.
- R5: Register 0x180 holds one enable bit per set, at bit 8+s. `irq_o` is the OR over all sets of summary bit 8+s ANDed with enable bit 8+s.
- R6: Register 0x190 holds one set-enable bit per set, at bit s. A write to the address of a set whose bit is 0 is dropped and changes no status.
- R7: A matching write with a data value of 32 or more is dropped. A write to a vector already pending changes nothing, so a single acknowledge clears it.
- R8: When a capture and a write-1-to-clear hit the same status bit in the same cycle, the capture wins and the bit stays 1.
- R9: After reset every register reads zero and `irq_o` is low. Unmapped offsets and the unused bits of 0x180, 0x184 and 0x190 read zero. Reads never change status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msi_valid | input | 1 | Inbound memory write strobe |
| msi_addr | input | 64 | Inbound write address |
| msi_data | input | 32 | Inbound write data (local vector index) |
| reg_addr | input | 12 | Register byte offset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| irq_o | output | 1 | Aggregated level interrupt |

## Verification
Each status bit is an independent flop. Corrupting one status bit therefore shows in the set's status readback, in the summary word and on `irq_o` in the first cycle after the faulty edge, provided that set's enables are on. Tests therefore open the enables before each capture, then read status, summary and the interrupt line one cycle after stimulus. A wrong address comparison or a wrong decode of the data value moves the captured bit into another set or another bit position. The bench reads neighbouring sets and exact bit patterns to catch this. Tests for masked or disabled paths look at both the raw status word and the gated outputs. This separates a lost capture from a masking fault.

// File: rtl/msi_agg_pkg.sv
package msi_agg_pkg;

   // Global register byte offsets
   localparam int OFS_INT_EN   = 32'h180;
   localparam int OFS_INT_STAT = 32'h184;
   localparam int OFS_SET_EN   = 32'h190;

   // Per-set low-address / status / vector-enable block
   localparam int SET_BLK_BASE   = 32'hC00;
   localparam int SET_BLK_STRIDE = 32'h010;
   localparam int SET_WORD_LO    = 32'h000;
   localparam int SET_WORD_STAT  = 32'h004;
   localparam int SET_WORD_VEN   = 32'h008;

   // Per-set high-address region
   localparam int HI_BLK_BASE    = 32'hC80;
   localparam int HI_BLK_STRIDE  = 32'h004;

   // Bit position of set 0 in the interrupt enable and summary words
   localparam int SUM_LSB = 8;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/msi_set_bank.sv
module msi_set_bank #(
   parameter int VEC_PER_SET = 32,
   parameter int REG_DW      = 32,
   parameter int CAP_AW      = 64
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       set_active,
   input  logic                       msi_valid,
   input  logic [CAP_AW-1:0]          msi_addr,
   input  logic [REG_DW-1:0]          msi_data,
   input  logic                       lo_we,
   input  logic                       hi_we,
   input  logic                       ack_we,
   input  logic                       ven_we,
   input  logic [REG_DW-1:0]          wdata,
   output logic [REG_DW-1:0]          addr_lo,
   output logic [CAP_AW-REG_DW-1:0]   addr_hi,
   output logic [VEC_PER_SET-1:0]     status,
   output logic [VEC_PER_SET-1:0]     vec_en,
   output logic                       pending
);

   localparam int IDX_W = $clog2(VEC_PER_SET);
   localparam int HI_W  = CAP_AW - REG_DW;
   localparam logic [VEC_PER_SET-1:0] ONE_HOT0 = {{(VEC_PER_SET-1){1'b0}}, 1'b1};

   logic                   hit;
   logic [VEC_PER_SET-1:0] raise_bits;
   logic [VEC_PER_SET-1:0] clear_bits;

   always_comb begin
      hit = set_active && msi_valid
            && (msi_addr == {addr_hi, addr_lo})
            && (msi_data < REG_DW'(VEC_PER_SET));
      raise_bits = hit ? (ONE_HOT0 << msi_data[IDX_W-1:0]) : '0;
      clear_bits = ack_we ? wdata[VEC_PER_SET-1:0] : '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_lo <= '0;
         addr_hi <= '0;
         vec_en  <= '0;
         status  <= '0;
      end else begin
         if (lo_we)  addr_lo <= wdata;
         if (hi_we)  addr_hi <= wdata[HI_W-1:0];
         if (ven_we) vec_en  <= wdata[VEC_PER_SET-1:0];
         // capture has priority over acknowledge on the same bit
         status <= (status & ~clear_bits) | raise_bits;
      end
   end

   assign pending = |(status & vec_en);

   AST_CAPTURE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (set_active && msi_valid && msi_addr == {addr_hi, addr_lo}
       && msi_data < REG_DW'(VEC_PER_SET))
      |=> status[$past(msi_data[IDX_W-1:0])]); // R2

   AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
      !(set_active && msi_valid && msi_addr == {addr_hi, addr_lo}
        && msi_data < REG_DW'(VEC_PER_SET))
      |=> ((status & ~$past(status)) == '0)); // R6

   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_we && !msi_valid) |=> ((status & $past(wdata[VEC_PER_SET-1:0])) == '0)); // R3

   AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      !ack_we |=> ((status & $past(status)) == $past(status))); // R7

endmodule

// File: rtl/msi_irq_combine.sv
module msi_irq_combine #(
   parameter int NUM_SETS = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_SETS-1:0] set_pending,
   input  logic [NUM_SETS-1:0] irq_en,
   output logic [NUM_SETS-1:0] summary,
   output logic                irq
);

   assign summary = set_pending;
   assign irq     = |(set_pending & irq_en);

   AST_IRQ_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (set_pending != '0)); // R5

endmodule

// File: rtl/pcie_msi_aggregator.sv
module pcie_msi_aggregator
   import msi_agg_pkg::*;
#(
   parameter int NUM_SETS    = 8,
   parameter int VEC_PER_SET = 32,
   parameter int REG_DW      = 32,
   parameter int REG_AW      = 12,
   parameter int CAP_AW      = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              msi_valid,
   input  logic [CAP_AW-1:0] msi_addr,
   input  logic [REG_DW-1:0] msi_data,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic              reg_we,
   input  logic [REG_DW-1:0] reg_wdata,
   output logic [REG_DW-1:0] reg_rdata,
   output logic              irq_o
);

   localparam int HI_W = CAP_AW - REG_DW;

   // Elaboration-time parameter checks
   if (NUM_SETS < 1 || NUM_SETS > 8) begin : g_bad_sets
      $error("NUM_SETS must be 1..8 to fit the summary and enable fields");
   end
   if (!is_pow2(VEC_PER_SET) || VEC_PER_SET < 2 || VEC_PER_SET > REG_DW) begin : g_bad_vec
      $error("VEC_PER_SET must be a power of two between 2 and REG_DW");
   end
   if (CAP_AW != 2 * REG_DW) begin : g_bad_aw
      $error("CAP_AW must be twice REG_DW");
   end
   if (REG_AW < 12) begin : g_bad_raw
      $error("REG_AW must reach offset 0xC9C");
   end

   localparam logic [REG_AW-1:0] A_INT_EN   = REG_AW'(OFS_INT_EN);
   localparam logic [REG_AW-1:0] A_INT_STAT = REG_AW'(OFS_INT_STAT);
   localparam logic [REG_AW-1:0] A_SET_EN   = REG_AW'(OFS_SET_EN);

   logic [NUM_SETS-1:0] int_en_q;
   logic [NUM_SETS-1:0] set_en_q;
   logic [NUM_SETS-1:0] set_pending;
   logic [NUM_SETS-1:0] summary;
   logic [REG_DW-1:0]   set_rd [NUM_SETS];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         int_en_q <= '0;
         set_en_q <= '0;
      end else if (reg_we) begin
         if (reg_addr == A_INT_EN) int_en_q <= reg_wdata[SUM_LSB +: NUM_SETS];
         if (reg_addr == A_SET_EN) set_en_q <= reg_wdata[NUM_SETS-1:0];
      end
   end

   for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
      localparam logic [REG_AW-1:0] A_LO   = REG_AW'(SET_BLK_BASE + s*SET_BLK_STRIDE + SET_WORD_LO);
      localparam logic [REG_AW-1:0] A_STAT = REG_AW'(SET_BLK_BASE + s*SET_BLK_STRIDE + SET_WORD_STAT);
      localparam logic [REG_AW-1:0] A_VEN  = REG_AW'(SET_BLK_BASE + s*SET_BLK_STRIDE + SET_WORD_VEN);
      localparam logic [REG_AW-1:0] A_HI   = REG_AW'(HI_BLK_BASE + s*HI_BLK_STRIDE);

      logic [REG_DW-1:0]      lo;
      logic [HI_W-1:0]        hi;
      logic [VEC_PER_SET-1:0] st;
      logic [VEC_PER_SET-1:0] ven;

      msi_set_bank #(
         .VEC_PER_SET (VEC_PER_SET),
         .REG_DW      (REG_DW),
         .CAP_AW      (CAP_AW)
      ) u_bank (
         .clk        (clk),
         .rst_n      (rst_n),
         .set_active (set_en_q[s]),
         .msi_valid  (msi_valid),
         .msi_addr   (msi_addr),
         .msi_data   (msi_data),
         .lo_we      (reg_we && reg_addr == A_LO),
         .hi_we      (reg_we && reg_addr == A_HI),
         .ack_we     (reg_we && reg_addr == A_STAT),
         .ven_we     (reg_we && reg_addr == A_VEN),
         .wdata      (reg_wdata),
         .addr_lo    (lo),
         .addr_hi    (hi),
         .status     (st),
         .vec_en     (ven),
         .pending    (set_pending[s])
      );

      always_comb begin
         set_rd[s] = '0;
         if (reg_addr == A_LO)   set_rd[s] = lo;
         if (reg_addr == A_HI)   set_rd[s] = REG_DW'(hi);
         if (reg_addr == A_STAT) set_rd[s] = REG_DW'(st);
         if (reg_addr == A_VEN)  set_rd[s] = REG_DW'(ven);
      end
   end

   msi_irq_combine #(
      .NUM_SETS (NUM_SETS)
   ) u_combine (
      .clk         (clk),
      .rst_n       (rst_n),
      .set_pending (set_pending),
      .irq_en      (int_en_q),
      .summary     (summary),
      .irq         (irq_o)
   );

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == A_INT_EN)   reg_rdata[SUM_LSB +: NUM_SETS] = int_en_q;
      if (reg_addr == A_INT_STAT) reg_rdata[SUM_LSB +: NUM_SETS] = summary;
      if (reg_addr == A_SET_EN)   reg_rdata[NUM_SETS-1:0]        = set_en_q;
      for (int s = 0; s < NUM_SETS; s++) reg_rdata = reg_rdata | set_rd[s];
   end

   AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (int_en_q == '0) |-> !irq_o); // R5

   AST_DISABLED_SET_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (set_en_q == '0) |=> ($past(set_pending) == '0) |-> (set_pending == '0)); // R6

endmodule

// File: tb/tb_pcie_msi_aggregator.sv
module tb_pcie_msi_aggregator;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        msi_valid = 1'b0;
   logic [63:0] msi_addr = '0;
   logic [31:0] msi_data = '0;
   logic [11:0] reg_addr = '0;
   logic        reg_we = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq_o;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   pcie_msi_aggregator dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .msi_valid (msi_valid),
      .msi_addr  (msi_addr),
      .msi_data  (msi_data),
      .reg_addr  (reg_addr),
      .reg_we    (reg_we),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .irq_o     (irq_o)
   );

   function automatic logic [11:0] a_lo(input int s);   return 12'(32'hC00 + 16*s); endfunction
   function automatic logic [11:0] a_stat(input int s); return 12'(32'hC04 + 16*s); endfunction
   function automatic logic [11:0] a_ven(input int s);  return 12'(32'hC08 + 16*s); endfunction
   function automatic logic [11:0] a_hi(input int s);   return 12'(32'hC80 + 4*s);  endfunction
   function automatic logic [63:0] cap(input int s);
      return {32'(32'h0000_0002 + s), 32'(32'hFE00_1000 + 16*s)};
   endfunction

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic msi(input logic [63:0] a, input logic [31:0] d);
      @(negedge clk);
      msi_addr = a; msi_data = d; msi_valid = 1'b1;
      @(negedge clk);
      msi_valid = 1'b0;
      #1;
   endtask

   task automatic t_reset;
      logic [31:0] d;
      rd(12'h180, d); check("R9 int_en reset", d, 0);
      rd(12'h184, d); check("R9 summary reset", d, 0);
      rd(12'h190, d); check("R9 set_en reset", d, 0);
      rd(a_stat(0), d); check("R9 status reset", d, 0);
      check("R9 irq reset", 32'(irq_o), 0);
   endtask

   task automatic t_program;
      logic [31:0] d;
      for (int s = 0; s < 8; s++) begin
         wr(a_lo(s), cap(s)[31:0]);
         wr(a_hi(s), cap(s)[63:32]);
         wr(a_ven(s), 32'hFFFF_FFFF);
      end
      wr(12'h190, 32'hFFFF_FFFF);
      wr(12'h180, 32'hFFFF_FFFF);
      rd(a_lo(3), d); check("R1 lo readback", d, cap(3)[31:0]);
      rd(a_hi(3), d); check("R1 hi readback", d, cap(3)[63:32]);
      rd(12'h190, d); check("R9 set_en unused bits", d, 32'h0000_00FF);
      rd(12'h180, d); check("R9 int_en unused bits", d, 32'h0000_FF00);
      rd(12'hC0C, d); check("R9 unmapped C0C", d, 0);
      rd(12'h188, d); check("R9 unmapped 188", d, 0);
   endtask

   task automatic t_capture;
      logic [31:0] d;
      msi(cap(2), 5);
      check("R5 irq after capture", 32'(irq_o), 1);
      rd(a_stat(2), d); check("R2 status bit", d, 32'h20);
      rd(a_stat(1), d); check("R2 neighbour untouched", d, 0);
      rd(12'h184, d); check("R4 summary", d, 32'h400);
      msi(cap(77 / 32), 77 % 32);
      rd(a_stat(2), d); check("R1 vector 77 mapping", d, 32'h2020);
   endtask

   task automatic t_ack;
      logic [31:0] d;
      wr(a_stat(2), 32'h20);
      rd(a_stat(2), d); check("R3 clear one bit", d, 32'h2000);
      wr(a_stat(2), 32'h0);
      rd(a_stat(2), d); check("R3 zero write no effect", d, 32'h2000);
      wr(a_stat(2), 32'h2000);
      rd(a_stat(2), d); check("R3 clear last bit", d, 0);
      check("R5 irq drops", 32'(irq_o), 0);
   endtask

   task automatic t_mask;
      logic [31:0] d;
      wr(a_ven(4), 32'h0);
      msi(cap(4), 0);
      rd(a_stat(4), d); check("R4 raw status while masked", d, 1);
      rd(12'h184, d); check("R4 summary masked", d, 0);
      check("R4 irq masked", 32'(irq_o), 0);
      wr(a_ven(4), 32'h1);
      check("R4 irq unmasked", 32'(irq_o), 1);
      wr(12'h180, 32'h0000_EF00);
      check("R5 set irq enable off", 32'(irq_o), 0);
      rd(12'h184, d); check("R5 summary ignores int_en", d, 32'h1000);
      wr(12'h180, 32'h0000_FF00);
      wr(a_stat(4), 32'hFFFF_FFFF);
      wr(a_ven(4), 32'hFFFF_FFFF);
   endtask

   task automatic t_set_disable;
      logic [31:0] d;
      wr(12'h190, 32'h0000_00BF);
      msi(cap(6), 9);
      rd(a_stat(6), d); check("R6 disabled set drops", d, 0);
      check("R6 irq stays low", 32'(irq_o), 0);
      wr(12'h190, 32'h0000_00FF);
      msi(cap(6), 9);
      rd(a_stat(6), d); check("R6 re-enabled set captures", d, 32'h200);
      wr(a_stat(6), 32'h200);
   endtask

   task automatic t_drop;
      logic [31:0] d;
      msi(cap(0), 32);
      rd(a_stat(0), d); check("R7 data 32 dropped", d, 0);
      msi(cap(0), 32'hFFFF_FFFF);
      rd(a_stat(0), d); check("R7 data max dropped", d, 0);
      msi(cap(0) + 64'd4, 1);
      rd(a_stat(0), d); check("R2 address miss", d, 0);
      msi(cap(0) ^ 64'h1_0000_0000, 1);
      rd(a_stat(0), d); check("R2 high word miss", d, 0);
      msi(cap(0), 31);
      msi(cap(0), 31);
      rd(a_stat(0), d); check("R7 repeat absorbed", d, 32'h8000_0000);
      wr(a_stat(0), 32'h8000_0000);
      rd(a_stat(0), d); check("R7 one ack clears", d, 0);
   endtask

   task automatic t_race;
      logic [31:0] d;
      msi(cap(7), 3);
      @(negedge clk);
      msi_addr = cap(7); msi_data = 3; msi_valid = 1'b1;
      reg_addr = a_stat(7); reg_wdata = 32'h8; reg_we = 1'b1;
      @(negedge clk);
      msi_valid = 1'b0; reg_we = 1'b0;
      rd(a_stat(7), d); check("R8 capture wins", d, 32'h8);
      rd(a_stat(7), d); check("R9 read has no side effect", d, 32'h8);
      rd(12'h184, d); check("R9 summary after reads", d, 32'h8000);
      wr(a_stat(7), 32'h8);
      rd(a_stat(7), d); check("R3 race bit acked", d, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_program();
      t_capture();
      t_ack();
      t_mask();
      t_set_disable();
      t_drop();
      t_race();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule